// File: doc/BRIEF.md
# Single-Channel PWM Generator with Period-Synchronous Update

This block produces one pulse-width-modulated output. A two-stage prescaler sets the rate of an 8-bit step counter. The first stage divides the input clock by a power of two, and the second stage divides that result by a linear factor. The step counter runs from zero up to a programmed span and then wraps. The output goes high when the step count reaches a programmed rise point. It goes low when the count reaches a programmed fall point. One full output period lasts (lin + 1) × 2^shift × (span + 1) input clocks.

A host programs the channel through a plain write strobe. There is no handshake. A write is accepted in every cycle in which `wr_en` is high. The host writes two 32-bit words: a control word and a duty word. Duty words are held in a staging register. The channel copies them into its active set only at a period wrap, while the clock gate is off, or at once when period sync is turned off. This keeps every period glitch-free. The gates, inversion and level mode come from the control word and act in the cycle after the write.

Top module: `pwm_sync_chan`

## Requirements
- R1: The control word at `wr_addr`=0 holds the prescaler fields: lin in bits 7:0 and shift in bits 11:8. The duty word at `wr_addr`=1 holds span in bits 31:24. The output period is (lin+1)·2^shift·(span+1) clocks, with one rising edge per period.
- R2: Rise point is duty bits 7:0 and fall point is duty bits 15:8. When rise < fall, the output is high for steps rise..fall−1. When rise > fall, it is high from rise through the wrap up to fall−1.
- R3: When rise equals fall, the output is high for the whole period.
- R4: While the pin gate (control bit 12) is 0, `pin_out` is 0 whatever the other settings are.
- R5: While the clock gate (control bit 16) is 0, the output is 0 and the counters are held at zero. Duty written meanwhile is used as soon as the gate is set again.
- R6: The invert bit (control bit 14) flips the output in the cycle after the write, without waiting for a wrap.
- R7: While the sync-off bit (control bit 17) is 0, a duty write changes the output only from the next period wrap.
- R8: While the sync-off bit is 1, a duty write takes effect in the cycle after the write.
- R9: `od_en` equals the open-drain bit (control bit 13) ANDed with the pin gate.
- R10: After reset every register is clear, and `pin_out` and `od_en` are 0.
- R11: The level bit (control bit 15) replaces the waveform with a constant high. Inversion and gating still apply to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; the word is taken at the rising edge |
| wr_addr | input | 1 | 0 selects the control word, 1 the duty word |
| wr_data | input | 32 | Word to write |
| pin_out | output | 1 | PWM level toward the pin |
| od_en | output | 1 | Open-drain drive enable |

## Verification
The assertions assume that the host changes the duty word only through the write port. They also assume that the control register is the only source of the gates. The sync-hold property further assumes that a staged duty word cannot reach the active set except at a wrap while sync is on. The stimulus keeps the span at or above the current step count whenever sync is off. It also turns the clock gate off before it re-times a test. As a result, every measurement starts with the counters at zero.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  localparam int DIVL_W = 8;
  localparam int DIVH_W = 4;
  localparam int CNT_W  = 8;

  typedef struct packed {
    logic              sync_off;
    logic              clk_on;
    logic              level;
    logic              invert;
    logic              od;
    logic              pin_on;
    logic [DIVH_W-1:0] shift;
    logic [DIVL_W-1:0] lin;
  } ctrl_t;

  typedef struct packed {
    logic [CNT_W-1:0] span;
    logic [CNT_W-1:0] fall;
    logic [CNT_W-1:0] rise;
  } duty_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIVL_W = 8,
  parameter int DIVH_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIVH_W-1:0] shift,
  input  logic [DIVL_W-1:0] lin,
  output logic              step
);
  localparam int P2_W = (1 << DIVH_W) - 1;

  logic [P2_W-1:0]   p2_q;
  logic [P2_W-1:0]   mask;
  logic [DIVL_W-1:0] lin_q;
  logic              tick;

  always_comb begin
    mask = (P2_W'(1) << shift) - P2_W'(1);
    tick = (p2_q & mask) == mask;
    step = tick && (lin_q >= lin);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p2_q  <= '0;
      lin_q <= '0;
    end else if (!run) begin
      p2_q  <= '0;
      lin_q <= '0;
    end else begin
      p2_q <= p2_q + P2_W'(1);
      if (tick) lin_q <= (lin_q >= lin) ? '0 : lin_q + DIVL_W'(1);
    end
  end

  p_lin_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (lin_q == '0 && p2_q == '0));
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
  import pwm_sync_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic             sync_off,
  input  duty_t            staged,
  output logic [CNT_W-1:0] cnt,
  output duty_t            act
);
  logic [CNT_W-1:0] cnt_q;
  duty_t            act_q;
  logic             wrap;
  logic             load;

  assign wrap = step && (cnt_q >= act_q.span);
  assign load = !run || sync_off || wrap;
  assign cnt  = cnt_q;
  assign act  = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      if (!run)      cnt_q <= '0;
      else if (step) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
      if (load) act_q <= staged;
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == '0);
  p_sync_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sync_off && !wrap) |=> $stable(act_q));
  p_nosync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sync_off) |=> act_q == $past(staged));
endmodule

// File: rtl/pwm_shaper.sv
module pwm_shaper
  import pwm_sync_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  duty_t            act,
  input  ctrl_t            ctrl,
  output logic             pin_out,
  output logic             od_en
);
  logic win;
  logic shaped;

  always_comb begin
    if (act.rise == act.fall)     win = 1'b1;
    else if (act.rise < act.fall) win = (cnt >= act.rise) && (cnt < act.fall);
    else                          win = (cnt >= act.rise) || (cnt < act.fall);
    shaped  = ctrl.level ? 1'b1 : win;
    pin_out = ctrl.pin_on && ctrl.clk_on && (shaped ^ ctrl.invert);
    od_en   = ctrl.od && ctrl.pin_on;
  end

  p_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.pin_on && ctrl.clk_on && !ctrl.invert && act.rise == act.fall) |-> pin_out);
  p_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.pin_on && ctrl.clk_on && ctrl.level) |-> (pin_out != ctrl.invert));
endmodule

// File: rtl/pwm_sync_chan.sv
module pwm_sync_chan
  import pwm_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  output logic        pin_out,
  output logic        od_en
);
  ctrl_t            ctrl_q;
  duty_t            staged_q;
  duty_t            act;
  logic [CNT_W-1:0] cnt;
  logic             step;
  logic             unused_bits;

  assign unused_bits = ^wr_data[23:18];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      staged_q <= '0;
    end else if (wr_en) begin
      if (!wr_addr) ctrl_q   <= ctrl_t'(wr_data[17:0]);
      else          staged_q <= duty_t'({wr_data[31:24], wr_data[15:0]});
    end
  end

  pwm_prescaler #(.DIVL_W(DIVL_W), .DIVH_W(DIVH_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.clk_on),
    .shift(ctrl_q.shift), .lin(ctrl_q.lin), .step(step));

  pwm_period_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.clk_on), .step(step),
    .sync_off(ctrl_q.sync_off), .staged(staged_q), .cnt(cnt), .act(act));

  pwm_shaper u_shp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .act(act), .ctrl(ctrl_q),
    .pin_out(pin_out), .od_en(od_en));

  p_pin_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.pin_on |-> !pin_out);
  p_clk_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.clk_on |-> !pin_out);
  p_od_r9: assert property (@(posedge clk) disable iff (!rst_n)
    od_en |-> (ctrl_q.pin_on && ctrl_q.od));
endmodule

// File: tb/test_pwm_sync_chan.sv
module test_pwm_sync_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic pin_out, od_en;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  pwm_sync_chan i_pwm_sync_chan (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pin_out(pin_out), .od_en(od_en));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // behavioural reference model
  int m_lin, m_sh, m_pin, m_od, m_inv, m_lvl, m_run, m_soff;
  int s_rise, s_fall, s_span, a_rise, a_fall, a_span, m_p2, m_lc, m_cnt;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
    if (!rst_n) begin
      m_lin = 0; m_sh = 0; m_pin = 0; m_od = 0; m_inv = 0; m_lvl = 0; m_run = 0; m_soff = 0;
      s_rise = 0; s_fall = 0; s_span = 0; a_rise = 0; a_fall = 0; a_span = 0;
      m_p2 = 0; m_lc = 0; m_cnt = 0;
    end else begin
      bit tick, stp, bnd;
      tick = (m_p2 % (1 << m_sh)) == ((1 << m_sh) - 1);
      stp  = tick && (m_lc >= m_lin);
      bnd  = stp && (m_cnt >= a_span);
      if (m_run == 0) begin
        m_p2 = 0; m_lc = 0; m_cnt = 0;
      end else begin
        m_p2 = (m_p2 + 1) % 32768;
        if (tick) m_lc = (m_lc >= m_lin) ? 0 : m_lc + 1;
        if (stp) m_cnt = bnd ? 0 : m_cnt + 1;
      end
      if (m_run == 0 || m_soff != 0 || bnd) begin
        a_rise = s_rise; a_fall = s_fall; a_span = s_span;
      end
      if (wr_en) begin
        if (!wr_addr) begin
          m_lin = wr_data[7:0]; m_sh = wr_data[11:8]; m_pin = wr_data[12];
          m_od = wr_data[13]; m_inv = wr_data[14]; m_lvl = wr_data[15];
          m_run = wr_data[16]; m_soff = wr_data[17];
        end else begin
          s_rise = wr_data[7:0]; s_fall = wr_data[15:8]; s_span = wr_data[31:24];
        end
      end
    end
  end

  function automatic int exp_pin();
    int win;
    if (a_rise == a_fall)     win = 1;
    else if (a_rise < a_fall) win = (m_cnt >= a_rise && m_cnt < a_fall) ? 1 : 0;
    else                      win = (m_cnt >= a_rise || m_cnt < a_fall) ? 1 : 0;
    if (m_lvl != 0) win = 1;
    if (m_run == 0 || m_pin == 0) return 0;
    return win ^ m_inv;
  endfunction

  always @(negedge clk) begin
    if (rst_n && cyc > 2) begin
      check(pin_out == exp_pin(), "R2 model pin_out", int'(pin_out), exp_pin());
      check(od_en == (m_od & m_pin), "R9 model od_en", int'(od_en), m_od & m_pin);
    end
  end

  function automatic logic [31:0] mk_ctrl(int lin, int sh, bit pin, bit od, bit inv,
                                          bit lvl, bit run, bit soff);
    return {14'd0, soff, run, lvl, inv, od, pin, 4'(sh), 8'(lin)};
  endfunction

  function automatic logic [31:0] mk_duty(int span, int fall, int rise);
    return {8'(span), 8'h00, 8'(fall), 8'(rise)};
  endfunction

  task automatic wr(input bit a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin_out) hi++;
    end
  endtask

  task automatic count_rises(input int n, output int r);
    logic prev;
    r = 0;
    @(negedge clk);
    prev = pin_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pin_out && !prev) r++;
      prev = pin_out;
    end
  endtask

  // restart the counters from zero with a new duty word
  task automatic restart(input logic [31:0] c_on, input logic [31:0] duty);
    logic [31:0] c_off;
    c_off = c_on;
    c_off[16] = 1'b0;
    wr(1'b0, c_off);
    wr(1'b1, duty);
    wr(1'b0, c_on);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    check(pin_out == 1'b0, "R10 pin_out after reset", int'(pin_out), 0);
    check(od_en == 1'b0, "R10 od_en after reset", int'(od_en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(pin_out == 1'b0, "R10 pin_out idle", int'(pin_out), 0);

    // R1/R2: 4 clocks per step, span 9 -> 40 clocks per period
    restart(mk_ctrl(1, 1, 1, 1, 0, 0, 1, 0), mk_duty(9, 5, 2));
    count_high(40, v);  check(v == 12, "R2 high clocks rise<fall", v, 12);
    count_rises(80, v); check(v == 2, "R1 rises in two periods", v, 2);
    check(od_en == 1'b1, "R9 od_en with pin gate", int'(od_en), 1);

    // R1: lin=2, shift=2 -> 12 clocks per step, span 4 -> 60 clocks
    restart(mk_ctrl(2, 2, 1, 0, 0, 0, 1, 0), mk_duty(4, 1, 0));
    count_high(60, v);  check(v == 12, "R1 high clocks alt divider", v, 12);
    count_rises(120, v); check(v == 2, "R1 rises alt divider", v, 2);
    check(od_en == 1'b0, "R9 od_en with od bit clear", int'(od_en), 0);

    // R2 wrap case
    restart(mk_ctrl(1, 1, 1, 1, 0, 0, 1, 0), mk_duty(9, 5, 2));
    wr(1'b1, mk_duty(9, 3, 7));
    repeat (80) @(negedge clk);
    count_high(40, v); check(v == 24, "R2 high clocks rise>fall", v, 24);

    // R3
    wr(1'b1, mk_duty(9, 4, 4));
    repeat (80) @(negedge clk);
    count_high(40, v); check(v == 40, "R3 equal points full high", v, 40);

    // R6 invert acts at once
    wr(1'b0, mk_ctrl(1, 1, 1, 1, 1, 0, 1, 0));
    check(pin_out == 1'b0, "R6 invert immediate", int'(pin_out), 0);
    count_high(40, v); check(v == 0, "R6 inverted full duty", v, 0);
    wr(1'b0, mk_ctrl(1, 1, 1, 1, 0, 0, 1, 0));
    check(pin_out == 1'b1, "R6 invert cleared", int'(pin_out), 1);

    // R11 level mode
    wr(1'b1, mk_duty(9, 5, 2));
    repeat (80) @(negedge clk);
    wr(1'b0, mk_ctrl(1, 1, 1, 1, 0, 1, 1, 0));
    count_high(40, v); check(v == 40, "R11 level constant high", v, 40);
    wr(1'b0, mk_ctrl(1, 1, 1, 1, 1, 1, 1, 0));
    count_high(40, v); check(v == 0, "R11 level with invert", v, 0);

    // R4 pin gate
    wr(1'b0, mk_ctrl(1, 1, 0, 1, 0, 0, 1, 0));
    count_high(40, v); check(v == 0, "R4 pin gate low", v, 0);
    check(od_en == 1'b0, "R4 od_en follows pin gate", int'(od_en), 0);

    // R5 clock gate, duty staged while off
    wr(1'b0, mk_ctrl(1, 1, 1, 1, 0, 0, 0, 0));
    wr(1'b1, mk_duty(9, 8, 0));
    count_high(40, v); check(v == 0, "R5 clock gate low", v, 0);
    wr(1'b0, mk_ctrl(1, 1, 1, 1, 0, 0, 1, 0));
    count_high(40, v); check(v == 32, "R5 new duty after re-enable", v, 32);

    // R7 sync: mid-period duty write deferred
    restart(mk_ctrl(1, 1, 1, 0, 0, 0, 1, 0), mk_duty(9, 5, 0));
    repeat (9) @(negedge clk);
    wr(1'b1, mk_duty(9, 1, 0));
    repeat (2) @(negedge clk);
    check(pin_out == 1'b1, "R7 duty change deferred", int'(pin_out), 1);
    repeat (80) @(negedge clk);
    count_high(40, v); check(v == 4, "R7 duty applied after wrap", v, 4);

    // R8 sync off: same write acts at once
    restart(mk_ctrl(1, 1, 1, 0, 0, 0, 1, 1), mk_duty(9, 5, 0));
    repeat (9) @(negedge clk);
    wr(1'b1, mk_duty(9, 1, 0));
    repeat (2) @(negedge clk);
    check(pin_out == 1'b0, "R8 duty change immediate", int'(pin_out), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule